// File: doc/BRIEF.md
# Interrupt Pending and Exception-Entry Unit

This unit gathers a bank of level-sensitive external interrupt lines into a sticky pending register. It qualifies the pending bits with a per-line mask and a global active-enable bit. When a serviceable interrupt is found at an instruction boundary, it issues a single-cycle exception-entry request to the fetch stage. The request carries the program counter to be saved as the exception return address and the handler address. The handler address is a software-programmed base plus the interrupt cause number times 32.

Software reaches the pending, mask, enable and base registers through a small register port. Register address 0 is pending, where writing ones clears the matching bits. Address 1 is the mask, address 2 the enable register, and address 3 the handler base. The enable register holds an active bit in bit 0 and a saved copy in bit 1. Entry disables interrupts and saves the old state. A return pulse restores the active bit from the saved copy. The unit keeps evaluating at every instruction boundary while any line is high, so a later change to the mask or to the enable bit is acted on.

Top module: `irq_entry_unit`

## Requirements
- R1: After reset, pending, mask, enable and base all read 0 and `entry_req` is low.
- R2: A high level on line i sets pending bit i (same index) by the next clock edge.
- R3: A pending bit stays set after its line returns low, until software clears it.
- R4: Writing a 1 to bit i at address 0 clears pending bit i unless line i is high in that cycle, in which case the bit stays set. Writing 0 leaves the bit unchanged.
- R5: Mask (address 1, bit i masks line i), enable (address 2: bit 0 active, bit 1 saved, upper bits read 0) and base (address 3) read back what was written. The low 8 bits of base always read 0.
- R6: `entry_req` rises for one cycle, one clock after a cycle with `insn_boundary` high, exactly when enable bit 0 is 1 and mask AND pending is non-zero. No entry happens otherwise.
- R7: With the request, `entry_save_pc` equals the `pc_cur` value of the boundary cycle. `entry_new_pc` equals base + CAUSE_ID*32, which is base + 0xA0 for the default cause 5.
- R8: Entry sets the enable register to 0x2. `entry_req` is never high two cycles in a row, and no further entry happens until bit 0 is set again.
- R9: An `eret_pulse` copies enable bit 1 into enable bit 0.
- R10: While any line is high, every boundary is evaluated. Once a boundary passes with all lines low, a pending bit left set is not evaluated again until some line goes high.
- R11: When entry coincides with an enable write or an `eret_pulse`, the entry's value 0x2 wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | 32 | External interrupt levels, line i maps to bit i |
| pc_cur | input | 32 | Current PC from fetch |
| insn_boundary | input | 1 | Instruction-boundary strobe from fetch |
| eret_pulse | input | 1 | Return-from-exception pulse |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 pending, 1 mask, 2 enable, 3 base |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| entry_req | output | 1 | One-cycle exception-entry request |
| entry_save_pc | output | 32 | PC to store as return address |
| entry_new_pc | output | 32 | Handler address |

## Verification
Assertions check the following on every cycle:
- pending bits are sticky,
- a high line sets its bit,
- the enable register holds 0x2 whenever a request is out,
- requests never occur back to back,
- a request only follows an enabled boundary,
- the return pulse restores the active bit.

Other behaviour needs the bench's scenarios to show it. This covers the computed handler address and saved PC, the mask test per line, and the end of the evaluation window once all lines are low. It also covers the clear-while-asserted case of the pending register and the priority of entry over a simultaneous enable write. The bench sweeps all 32 lines through mask-miss, window-closed and taken cases.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int XLEN = 32;

    typedef enum logic [1:0] {
        RA_PEND = 2'd0,
        RA_MASK = 2'd1,
        RA_ENAB = 2'd2,
        RA_BASE = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic saved;
        logic active;
    } enab_t;

    localparam enab_t ENAB_ON_ENTRY = '{saved: 1'b1, active: 1'b0};

    function automatic logic [XLEN-1:0] cause_offset(input int cause, input int shift);
        logic [XLEN-1:0] c;
        c = XLEN'(cause);
        return c << shift;
    endfunction

    function automatic logic [XLEN-1:0] low_zero_mask(input int nbits);
        logic [XLEN-1:0] m;
        m = '1;
        return m << nbits;
    endfunction

endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
    parameter int NUM_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] lines,
    input  logic [NUM_LINES-1:0] clr_vec,
    output logic [NUM_LINES-1:0] pend_q
);

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                pend_q[i] <= 1'b0;
            else if (lines[i])
                pend_q[i] <= 1'b1;
            else if (clr_vec[i])
                pend_q[i] <= 1'b0;
        end
    end

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((($past(pend_q) & ~$past(clr_vec)) & ~pend_q) == '0)); // R3

    AST_LINE_SETS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(lines) & ~pend_q) == '0)); // R2

endmodule

// File: rtl/irq_csr_file.sv
module irq_csr_file
    import irq_pkg::*;
#(
    parameter int NUM_LINES     = 32,
    parameter int BASE_LOW_ZERO = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  reg_addr_e            addr,
    input  logic [XLEN-1:0]      wdata,
    input  logic [NUM_LINES-1:0] pend,
    input  logic                 entry_take,
    input  logic                 eret,
    output logic [NUM_LINES-1:0] clr_vec,
    output logic [NUM_LINES-1:0] mask_q,
    output enab_t                enab_q,
    output logic [XLEN-1:0]      base_q,
    output logic [XLEN-1:0]      rdata
);

    localparam logic [XLEN-1:0] BASE_KEEP = low_zero_mask(BASE_LOW_ZERO);

    assign clr_vec = (we && addr == RA_PEND) ? wdata[NUM_LINES-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            base_q <= '0;
        end else if (we) begin
            if (addr == RA_MASK) mask_q <= wdata[NUM_LINES-1:0];
            if (addr == RA_BASE) base_q <= wdata & BASE_KEEP;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            enab_q <= '0;
        else if (entry_take)
            enab_q <= ENAB_ON_ENTRY;
        else if (eret)
            enab_q.active <= enab_q.saved;
        else if (we && addr == RA_ENAB)
            enab_q <= enab_t'(wdata[1:0]);
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            RA_PEND: rdata[NUM_LINES-1:0] = pend;
            RA_MASK: rdata[NUM_LINES-1:0] = mask_q;
            RA_ENAB: rdata[1:0]           = enab_q;
            RA_BASE: rdata                = base_q;
        endcase
    end

    AST_ERET_RESTORE: assert property (@(posedge clk) disable iff (rst)
        (eret && !entry_take) |=> (enab_q.active == $past(enab_q.saved))); // R9

endmodule

// File: rtl/irq_entry_ctl.sv
module irq_entry_ctl
    import irq_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int CAUSE_ID  = 5,
    parameter int VEC_SHIFT = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] lines,
    input  logic [NUM_LINES-1:0] pend,
    input  logic [NUM_LINES-1:0] mask,
    input  logic                 en_active,
    input  logic [XLEN-1:0]      base,
    input  logic [XLEN-1:0]      pc,
    input  logic                 boundary,
    output logic                 take,
    output logic                 req_q,
    output logic [XLEN-1:0]      save_pc_q,
    output logic [XLEN-1:0]      new_pc_q
);

    localparam logic [XLEN-1:0] CAUSE_OFS = cause_offset(CAUSE_ID, VEC_SHIFT);

    logic watch_q;
    logic any_line;
    logic watch;

    assign any_line = |lines;
    assign watch    = watch_q | any_line;
    assign take     = boundary && watch && en_active && (|(mask & pend));

    always_ff @(posedge clk) begin
        if (rst)
            watch_q <= 1'b0;
        else if (any_line)
            watch_q <= 1'b1;
        else if (boundary)
            watch_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q     <= 1'b0;
            save_pc_q <= '0;
            new_pc_q  <= '0;
        end else begin
            req_q <= take;
            if (take) begin
                save_pc_q <= pc;
                new_pc_q  <= base + CAUSE_OFS;
            end
        end
    end

    AST_REQ_AT_ENABLED_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        req_q |-> ($past(boundary) && $past(en_active))); // R6

endmodule

// File: rtl/irq_entry_unit.sv
module irq_entry_unit
    import irq_pkg::*;
#(
    parameter int NUM_LINES     = 32,
    parameter int CAUSE_ID      = 5,
    parameter int VEC_SHIFT     = 5,
    parameter int BASE_LOW_ZERO = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] irq_lines,
    input  logic [XLEN-1:0]      pc_cur,
    input  logic                 insn_boundary,
    input  logic                 eret_pulse,
    input  logic                 reg_we,
    input  logic [1:0]           reg_addr,
    input  logic [XLEN-1:0]      reg_wdata,
    output logic [XLEN-1:0]      reg_rdata,
    output logic                 entry_req,
    output logic [XLEN-1:0]      entry_save_pc,
    output logic [XLEN-1:0]      entry_new_pc
);

    logic [NUM_LINES-1:0] pend;
    logic [NUM_LINES-1:0] clr_vec;
    logic [NUM_LINES-1:0] mask;
    enab_t                enab;
    logic [XLEN-1:0]      base;
    logic                 take;

    irq_pend_bank #(.NUM_LINES(NUM_LINES)) u_pend (
        .clk     (clk),
        .rst     (rst),
        .lines   (irq_lines),
        .clr_vec (clr_vec),
        .pend_q  (pend)
    );

    irq_csr_file #(.NUM_LINES(NUM_LINES), .BASE_LOW_ZERO(BASE_LOW_ZERO)) u_csr (
        .clk        (clk),
        .rst        (rst),
        .we         (reg_we),
        .addr       (reg_addr_e'(reg_addr)),
        .wdata      (reg_wdata),
        .pend       (pend),
        .entry_take (take),
        .eret       (eret_pulse),
        .clr_vec    (clr_vec),
        .mask_q     (mask),
        .enab_q     (enab),
        .base_q     (base),
        .rdata      (reg_rdata)
    );

    irq_entry_ctl #(.NUM_LINES(NUM_LINES), .CAUSE_ID(CAUSE_ID), .VEC_SHIFT(VEC_SHIFT)) u_ctl (
        .clk       (clk),
        .rst       (rst),
        .lines     (irq_lines),
        .pend      (pend),
        .mask      (mask),
        .en_active (enab.active),
        .base      (base),
        .pc        (pc_cur),
        .boundary  (insn_boundary),
        .take      (take),
        .req_q     (entry_req),
        .save_pc_q (entry_save_pc),
        .new_pc_q  (entry_new_pc)
    );

    AST_ENTRY_DISABLES: assert property (@(posedge clk) disable iff (rst)
        entry_req |-> (enab == ENAB_ON_ENTRY)); // R8

    AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
        entry_req |=> !entry_req); // R8

endmodule

// File: tb/sim_irq_entry_unit.sv
`timescale 1ns/1ps
module sim_irq_entry_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] irq_lines = '0;
    logic [31:0] pc_cur = '0;
    logic        insn_boundary = 1'b0;
    logic        eret_pulse = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        entry_req;
    logic [31:0] entry_save_pc;
    logic [31:0] entry_new_pc;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    irq_entry_unit u0 (
        .clk(clk), .rst(rst), .irq_lines(irq_lines), .pc_cur(pc_cur),
        .insn_boundary(insn_boundary), .eret_pulse(eret_pulse),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .entry_req(entry_req),
        .entry_save_pc(entry_save_pc), .entry_new_pc(entry_new_pc)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        cyc();
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [31:0] exp, input string tag);
        reg_addr = a;
        #1;
        chk(reg_rdata === exp, tag, reg_rdata, exp);
    endtask

    task automatic boundary_at(input logic [31:0] pc);
        pc_cur = pc; insn_boundary = 1'b1;
        cyc();
        insn_boundary = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) cyc();
        rst = 1'b0;
        cyc();
        // R1 reset state
        chk(entry_req === 1'b0, "R1 entry_req", {31'b0, entry_req}, 32'h0);
        rd_chk(2'd0, 32'h0, "R1 pending");
        rd_chk(2'd1, 32'h0, "R1 mask");
        rd_chk(2'd2, 32'h0, "R1 enable");
        rd_chk(2'd3, 32'h0, "R1 base");

        // R5 register readback
        wr(2'd3, 32'hFFFF_FFFF);
        rd_chk(2'd3, 32'hFFFF_FF00, "R5 base low bits zero");
        wr(2'd1, 32'hA5C3_0F96);
        rd_chk(2'd1, 32'hA5C3_0F96, "R5 mask");
        wr(2'd2, 32'hFFFF_FFFE);
        rd_chk(2'd2, 32'h0000_0002, "R5 enable two bits");

        // R4 write-one-to-clear
        irq_lines = 32'h0000_0008;
        cyc();
        wr(2'd0, 32'h0000_0008);
        rd_chk(2'd0, 32'h0000_0008, "R4 clear while line high keeps bit");
        irq_lines = '0;
        cyc();
        wr(2'd0, 32'h0000_0000);
        rd_chk(2'd0, 32'h0000_0008, "R4 write zero no effect");
        wr(2'd0, 32'h0000_0008);
        rd_chk(2'd0, 32'h0000_0000, "R4 clear after line low");

        // Sweep every line
        for (int i = 0; i < 32; i++) begin
            logic [31:0] bitv;
            logic [31:0] basev;
            logic [31:0] pcv;
            bitv  = 32'h1 << i;
            basev = 32'h1000_0000 | (32'(i) << 8);
            pcv   = 32'h0000_4000 + 32'(i) * 4;
            wr(2'd0, 32'hFFFF_FFFF);
            wr(2'd3, basev);
            wr(2'd1, ~bitv);
            wr(2'd2, 32'h1);
            irq_lines = bitv;
            cyc();
            irq_lines = '0;
            rd_chk(2'd0, bitv, "R2 line sets own pending bit");
            cyc();
            rd_chk(2'd0, bitv, "R3 pending kept after line low");
            boundary_at(pcv);
            chk(entry_req === 1'b0, "R6 masked line no entry", {31'b0, entry_req}, 32'h0);
            wr(2'd1, bitv);
            boundary_at(pcv);
            chk(entry_req === 1'b0, "R10 window closed no entry", {31'b0, entry_req}, 32'h0);
            irq_lines = bitv;
            boundary_at(pcv);
            irq_lines = '0;
            chk(entry_req === 1'b1, "R6 entry taken", {31'b0, entry_req}, 32'h1);
            chk(entry_save_pc === pcv, "R7 saved pc", entry_save_pc, pcv);
            chk(entry_new_pc === basev + 32'd160, "R7 handler address", entry_new_pc, basev + 32'd160);
            rd_chk(2'd2, 32'h2, "R8 enable after entry");
            cyc();
            chk(entry_req === 1'b0, "R8 single cycle request", {31'b0, entry_req}, 32'h0);
            eret_pulse = 1'b1;
            cyc();
            eret_pulse = 1'b0;
            rd_chk(2'd2, 32'h3, "R9 eret restores active");
        end

        // R10 held line sees later mask change
        wr(2'd0, 32'hFFFF_FFFF);
        wr(2'd1, 32'h0);
        wr(2'd2, 32'h1);
        irq_lines = 32'h0001_0000;
        boundary_at(32'h100);
        chk(entry_req === 1'b0, "R10 held line masked", {31'b0, entry_req}, 32'h0);
        wr(2'd1, 32'h0001_0000);
        boundary_at(32'h104);
        chk(entry_req === 1'b1, "R10 held line after unmask", {31'b0, entry_req}, 32'h1);
        chk(entry_save_pc === 32'h104, "R7 saved pc held line", entry_save_pc, 32'h104);
        cyc();
        // R8 hold-off while bit 0 low
        boundary_at(32'h108);
        chk(entry_req === 1'b0, "R8 no entry while disabled", {31'b0, entry_req}, 32'h0);
        irq_lines = '0;

        // R11 entry wins over simultaneous enable write and eret
        wr(2'd2, 32'h1);
        reg_addr = 2'd2; reg_wdata = 32'h1; reg_we = 1'b1; eret_pulse = 1'b1;
        boundary_at(32'h200);
        reg_we = 1'b0; eret_pulse = 1'b0;
        chk(entry_req === 1'b1, "R11 entry taken", {31'b0, entry_req}, 32'h1);
        rd_chk(2'd2, 32'h2, "R11 enable forced 0x2");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule